// File: doc/BRIEF.md
# Multiprefix Combining Memory Unit

This block sits in front of a small word-addressed shared memory and serves several requesters at once. In any cycle, each request port may present a combining request: a word address, one of four integer operations and a 32-bit operand. Requests that name the same address and the same operation in the same cycle are merged into one group. Each group member gets back the word as it was before the group, combined in port-index order with the operands of every member on a lower-numbered port. The word itself is left holding the result of combining all the group's operands.

Requests to different addresses proceed side by side. When groups with different operations hit one address in one cycle, they are applied one after another, starting with the smallest operation code. A request may be flagged as non-returning. It then updates the word exactly like any other member but produces no response. A separate backdoor port loads words and reads them combinationally, for initialisation and inspection.

Top module: `mpc_unit`

## Requirements
- R1: Requests on the same cycle that carry the same address and the same operation form one group. Requests to other addresses are computed independently and do not disturb the group's results.
- R2: A returning member on port q receives the pre-group word combined, in ascending port order, with the operands of all group members on ports below q. The lowest-numbered member receives the pre-group word unchanged.
- R3: After a group is processed, its memory word equals the pre-group word combined with every operand of the group.
- R4: Operation codes on `req_op`: 2'b00 adds modulo 2^32, 2'b01 keeps the signed (two's complement) maximum, 2'b10 is bitwise AND, 2'b11 is bitwise OR.
- R5: If groups with different operation codes target one address in the same cycle, they are applied in ascending code order. The pre-group word seen by a higher-code group already includes every lower-code group's total.
- R6: `rsp_valid[q]` is high exactly two cycles after a returning request on port q, with `rsp_data[q]` valid in the same cycle and zero otherwise. A request issued in the cycle after another sees the earlier one's memory update.
- R7: A request with `req_sync` high updates the word and counts toward the prefixes of higher ports like any member, but its `rsp_valid` stays low.
- R8: `bd_rdata` shows the word at `bd_addr` combinationally, and `bd_we` writes `bd_wdata` at the clock edge. A group issued in the cycle of a backdoor write to its address sees the written value. A group commit that lands on the same edge as a backdoor write to the same word overrides the write.
- R9: While `rst_n` is low at a clock edge, all memory words are cleared to zero and every `rsp_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORT | Request present on each port |
| req_sync | input | NPORT | Non-returning flag per port |
| req_addr | input | NPORT x AW | Word address per port |
| req_op | input | NPORT x 2 | Operation code per port |
| req_operand | input | NPORT x 32 | Operand per port |
| rsp_valid | output | NPORT | Response present per port |
| rsp_data | output | NPORT x 32 | Prefix result per port |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | AW | Backdoor word address |
| bd_wdata | input | 32 | Backdoor write data |
| bd_rdata | output | 32 | Word at bd_addr |

## Verification
A backdoor write and a group commit can fall on the same clock edge at the same word. So can two groups with different operations at one address. The bench provokes the first by writing through the backdoor in the cycle after a group is issued to that word, and in the same cycle as another group to it. It provokes the second by splitting the ports of one address between two operation codes, and a random phase confined to four addresses makes both collisions frequent. A bench model applies backdoor writes, skipping those overridden by a commit. It then folds each group in code order and judges every response and, through backdoor reads, every final word.

// File: rtl/mpc_pkg.sv
// Shared definitions for the multiprefix combining memory unit:
// operation encoding and the combining function used by every stage.
package mpc_pkg;

    localparam int MP_DW      = 32;
    localparam int MP_NUM_OPS = 4;

    typedef enum logic [1:0] {
        MP_ADD = 2'd0,
        MP_MAX = 2'd1,
        MP_AND = 2'd2,
        MP_OR  = 2'd3
    } mp_op_e;

    // Combine an accumulator with one operand under the given operation.
    function automatic logic [MP_DW-1:0] mp_apply(input logic [1:0] op,
                                                   input logic [MP_DW-1:0] acc,
                                                   input logic [MP_DW-1:0] opnd);
        logic [MP_DW-1:0] res;
        case (op)
            MP_ADD:  res = acc + opnd;
            MP_MAX:  res = ($signed(acc) >= $signed(opnd)) ? acc : opnd;
            MP_AND:  res = acc & opnd;
            default: res = acc | opnd;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mpc_req_stage.sv
// Request capture stage.
// Registers all port requests at the end of the issue cycle so the
// combining network works from stable, aligned values one cycle later.
// Assumes: requests are only meaningful when their valid bit is set.
module mpc_req_stage
    import mpc_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            in_valid,
    input  logic [NPORT-1:0]            in_sync,
    input  logic [NPORT-1:0][AW-1:0]    in_addr,
    input  logic [NPORT-1:0][1:0]       in_op,
    input  logic [NPORT-1:0][MP_DW-1:0] in_operand,
    output logic [NPORT-1:0]            s_valid,
    output logic [NPORT-1:0]            s_sync,
    output logic [NPORT-1:0][AW-1:0]    s_addr,
    output logic [NPORT-1:0][1:0]       s_op,
    output logic [NPORT-1:0][MP_DW-1:0] s_operand
);

    // Capture the request vector; valid bits are cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid   <= '0;
            s_sync    <= '0;
            s_addr    <= '0;
            s_op      <= '0;
            s_operand <= '0;
        end else begin
            s_valid   <= in_valid;
            s_sync    <= in_sync;
            s_addr    <= in_addr;
            s_op      <= in_op;
            s_operand <= in_operand;
        end
    end

endmodule

// File: rtl/mpc_prefix_net.sv
// Ordered combining network.
// For every captured request it folds, in ascending operation code and then
// ascending port order, all requests to the same address. The fold stopped
// before the request itself is its prefix; the full fold is the word total.
// Assumes: old_word[q] is the current memory word at in_addr[q].
module mpc_prefix_net
    import mpc_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            in_valid,
    input  logic [NPORT-1:0][AW-1:0]    in_addr,
    input  logic [NPORT-1:0][1:0]       in_op,
    input  logic [NPORT-1:0][MP_DW-1:0] in_operand,
    input  logic [NPORT-1:0][MP_DW-1:0] old_word,
    output logic [NPORT-1:0][MP_DW-1:0] pfx,
    output logic [NPORT-1:0][MP_DW-1:0] total
);

    // Fold every same-address request into the prefix and total of each port.
    always_comb begin
        logic [MP_DW-1:0] acc;
        logic [MP_DW-1:0] tot;
        for (int q = 0; q < NPORT; q++) begin
            acc = old_word[q];
            tot = old_word[q];
            for (int k = 0; k < MP_NUM_OPS; k++) begin
                for (int j = 0; j < NPORT; j++) begin
                    if (in_valid[j] && in_addr[j] == in_addr[q] && in_op[j] == 2'(k)) begin
                        tot = mp_apply(2'(k), tot, in_operand[j]);
                        if ((2'(k) < in_op[q]) || (2'(k) == in_op[q] && j < q))
                            acc = mp_apply(2'(k), acc, in_operand[j]);
                    end
                end
            end
            pfx[q]   = acc;
            total[q] = tot;
        end
    end

    // R2
    lowest_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && in_op[0] == MP_ADD) |-> pfx[0] == old_word[0]);

    for (genvar q = 0; q < NPORT - 1; q++) begin : g_chain_chk
        // R2
        add_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[q] && in_valid[q+1] && in_addr[q] == in_addr[q+1] &&
             in_op[q] == MP_ADD && in_op[q+1] == MP_ADD)
            |-> pfx[q+1] == pfx[q] + in_operand[q]);
    end

endmodule

// File: rtl/mpc_word_mem.sv
// Shared word store.
// Provides one combinational read per request port, one commit write per
// request port, and a backdoor load/read port.
// Assumes: all commit writes to one word in a cycle carry the same value;
// a commit to a word wins over a backdoor write to it on the same edge.
module mpc_word_mem
    import mpc_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0][AW-1:0]    rd_addr,
    output logic [NPORT-1:0][MP_DW-1:0] rd_data,
    input  logic [NPORT-1:0]            cm_en,
    input  logic [NPORT-1:0][AW-1:0]    cm_addr,
    input  logic [NPORT-1:0][MP_DW-1:0] cm_data,
    input  logic                        bd_we,
    input  logic [AW-1:0]               bd_addr,
    input  logic [MP_DW-1:0]            bd_wdata,
    output logic [MP_DW-1:0]            bd_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [MP_DW-1:0] mem [DEPTH];

    // Clear on reset; apply the backdoor write, then the commits over it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else begin
            if (bd_we) mem[bd_addr] <= bd_wdata;
            for (int p = 0; p < NPORT; p++) begin
                if (cm_en[p]) mem[cm_addr[p]] <= cm_data[p];
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

    assign bd_rdata = mem[bd_addr];

endmodule

// File: rtl/mpc_unit.sv
// Multiprefix combining memory unit (top).
// Cycle t: requests presented. Edge ending t: captured. Edge ending t+1:
// prefixes computed against memory, totals committed, responses registered.
// Responses are visible in cycle t+2.
// Assumes: req_op uses the mpc_pkg encoding; non-returning requests still
// take part in their group.
module mpc_unit
    import mpc_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            req_valid,
    input  logic [NPORT-1:0]            req_sync,
    input  logic [NPORT-1:0][AW-1:0]    req_addr,
    input  logic [NPORT-1:0][1:0]       req_op,
    input  logic [NPORT-1:0][MP_DW-1:0] req_operand,
    output logic [NPORT-1:0]            rsp_valid,
    output logic [NPORT-1:0][MP_DW-1:0] rsp_data,
    input  logic                        bd_we,
    input  logic [AW-1:0]               bd_addr,
    input  logic [MP_DW-1:0]            bd_wdata,
    output logic [MP_DW-1:0]            bd_rdata
);

    logic [NPORT-1:0]            s_valid;
    logic [NPORT-1:0]            s_sync;
    logic [NPORT-1:0][AW-1:0]    s_addr;
    logic [NPORT-1:0][1:0]       s_op;
    logic [NPORT-1:0][MP_DW-1:0] s_operand;
    logic [NPORT-1:0][MP_DW-1:0] old_word;
    logic [NPORT-1:0][MP_DW-1:0] pfx;
    logic [NPORT-1:0][MP_DW-1:0] total;

    mpc_req_stage #(.NPORT(NPORT), .AW(AW)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_sync    (req_sync),
        .in_addr    (req_addr),
        .in_op      (req_op),
        .in_operand (req_operand),
        .s_valid    (s_valid),
        .s_sync     (s_sync),
        .s_addr     (s_addr),
        .s_op       (s_op),
        .s_operand  (s_operand)
    );

    mpc_prefix_net #(.NPORT(NPORT), .AW(AW)) u_net (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s_valid),
        .in_addr    (s_addr),
        .in_op      (s_op),
        .in_operand (s_operand),
        .old_word   (old_word),
        .pfx        (pfx),
        .total      (total)
    );

    mpc_word_mem #(.NPORT(NPORT), .AW(AW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (s_addr),
        .rd_data  (old_word),
        .cm_en    (s_valid),
        .cm_addr  (s_addr),
        .cm_data  (total),
        .bd_we    (bd_we),
        .bd_addr  (bd_addr),
        .bd_wdata (bd_wdata),
        .bd_rdata (bd_rdata)
    );

    // Register per-port responses for returning requests; zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                rsp_valid[p] <= s_valid[p] && !s_sync[p];
                rsp_data[p]  <= (s_valid[p] && !s_sync[p]) ? pfx[p] : '0;
            end
        end
    end

    // R9
    rsp_reset_chk: assert property (@(posedge clk) !rst_n |=> rsp_valid == '0);

    for (genvar q = 0; q < NPORT; q++) begin : g_rsp_chk
        // R6
        rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[q] |-> $past(req_valid[q], 2));
        // R7
        sync_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid[q] && req_sync[q], 2) |-> !rsp_valid[q]);
    end

endmodule

// File: tb/mpc_unit_test.sv
module mpc_unit_test;

    localparam int NP    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NP-1:0]          req_valid = '0;
    logic [NP-1:0]          req_sync = '0;
    logic [NP-1:0][AW-1:0]  req_addr = '0;
    logic [NP-1:0][1:0]     req_op = '0;
    logic [NP-1:0][31:0]    req_operand = '0;
    logic [NP-1:0]          rsp_valid;
    logic [NP-1:0][31:0]    rsp_data;
    logic                   bd_we = 1'b0;
    logic [AW-1:0]          bd_addr = '0;
    logic [31:0]            bd_wdata = '0;
    logic [31:0]            bd_rdata;

    mpc_unit #(.NPORT(NP), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sync(req_sync), .req_addr(req_addr),
        .req_op(req_op), .req_operand(req_operand),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // staged stimulus for the next step
    logic [NP-1:0]         nv = '0, ns = '0;
    logic [NP-1:0][AW-1:0] na = '0;
    logic [NP-1:0][1:0]    no = '0;
    logic [NP-1:0][31:0]   nx = '0;
    logic                  nbd_we = 1'b0;
    logic [AW-1:0]         nbd_addr = '0;
    logic [31:0]           nbd_wdata = '0;

    // reference model
    logic [31:0]      model_mem [DEPTH];
    logic [DEPTH-1:0] last_commit = '0;
    logic             ev [3][NP];
    logic [31:0]      ed [3][NP];
    string            etag [3];
    int               cyc = 0;

    function automatic logic [31:0] ref_apply(input logic [1:0] op, input logic [31:0] a,
                                              input logic [31:0] b);
        if (op == 2'd0) return a + b;
        if (op == 2'd1) return ($signed(a) < $signed(b)) ? b : a;
        if (op == 2'd2) return a & b;
        return a | b;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_stage();
        nv = '0; ns = '0; na = '0; no = '0; nx = '0;
        nbd_we = 1'b0; nbd_addr = '0; nbd_wdata = '0;
    endtask

    // One cycle: check the batch from two steps ago, drive the staged one, model it.
    task automatic step(input string tag);
        int cs, ws;
        logic [31:0] acc [NP];
        logic [31:0] tot [NP];
        logic [DEPTH-1:0] newc;
        @(negedge clk);
        cs = (cyc + 1) % 3;
        ws = cyc % 3;
        for (int p = 0; p < NP; p++) begin
            chk(rsp_valid[p] == ev[cs][p], {etag[cs], " rsp_valid"},
                32'(rsp_valid[p]), 32'(ev[cs][p]));
            if (ev[cs][p])
                chk(rsp_data[p] == ed[cs][p], {etag[cs], " rsp_data"}, rsp_data[p], ed[cs][p]);
        end
        req_valid = nv; req_sync = ns; req_addr = na; req_op = no; req_operand = nx;
        bd_we = nbd_we; bd_addr = nbd_addr; bd_wdata = nbd_wdata;
        if (nbd_we && !last_commit[nbd_addr]) model_mem[nbd_addr] = nbd_wdata;
        newc = '0;
        for (int q = 0; q < NP; q++) begin
            acc[q] = model_mem[na[q]];
            tot[q] = model_mem[na[q]];
            for (int k = 0; k < 4; k++)
                for (int j = 0; j < NP; j++)
                    if (nv[j] && na[j] == na[q] && no[j] == 2'(k)) begin
                        tot[q] = ref_apply(2'(k), tot[q], nx[j]);
                        if (2'(k) < no[q] || (2'(k) == no[q] && j < q))
                            acc[q] = ref_apply(2'(k), acc[q], nx[j]);
                    end
        end
        for (int q = 0; q < NP; q++) begin
            if (nv[q]) begin
                model_mem[na[q]] = tot[q];
                newc[na[q]] = 1'b1;
            end
            ev[ws][q] = nv[q] && !ns[q];
            ed[ws][q] = acc[q];
        end
        etag[ws] = tag;
        last_commit = newc;
        cyc++;
        clear_stage();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("R6 idle");
    endtask

    // Backdoor read check between edges, after the pipeline has drained.
    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        bd_addr = a;
        #2;
        chk(bd_rdata == model_mem[a], tag, bd_rdata, model_mem[a]);
        bd_addr = '0;
    endtask

    initial begin
        for (int w = 0; w < DEPTH; w++) model_mem[w] = '0;
        for (int s = 0; s < 3; s++) begin
            etag[s] = "R6";
            for (int p = 0; p < NP; p++) begin ev[s][p] = 1'b0; ed[s][p] = '0; end
        end
        void'($urandom(32'd24681357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(rsp_valid == '0, "R9 rsp_valid after reset", 32'(rsp_valid), 0);
        for (int w = 0; w < 4; w++) rd_chk(AW'(w), "R9 word cleared");

        // R8: backdoor loads
        for (int w = 0; w < 6; w++) begin
            nbd_we = 1'b1; nbd_addr = AW'(w); nbd_wdata = 32'h100 * (w + 1);
            step("R8 load");
        end
        idle(2);
        for (int w = 0; w < 6; w++) rd_chk(AW'(w), "R8 backdoor read");

        // R2 R3: all ports add to one word
        for (int p = 0; p < NP; p++) begin nv[p] = 1; na[p] = 2; no[p] = 2'd0; nx[p] = 32'(p + 1); end
        step("R2 all-port add prefix");
        idle(2);
        rd_chk(2, "R3 add total");

        // R1 R4: four words, four operations, mixed signs for max
        for (int p = 0; p < NP; p++) begin
            nv[p] = 1; na[p] = AW'(p % 4); no[p] = 2'(p % 4);
            nx[p] = (p % 2 == 1) ? 32'hFFFF_FF00 + 32'(p) : 32'h0F0F_0000 + 32'(p);
        end
        step("R1 R4 independent groups");
        idle(2);
        for (int w = 0; w < 4; w++) rd_chk(AW'(w), "R4 per-op total");

        // R5: one word, OR on low ports, ADD on high ports
        for (int p = 0; p < NP; p++) begin
            nv[p] = 1; na[p] = 5; no[p] = (p < 4) ? 2'd3 : 2'd0; nx[p] = 32'(1 << p);
        end
        step("R5 op ordering");
        idle(2);
        rd_chk(5, "R5 ordered total");

        // R7: non-returning members mixed with returning ones
        for (int p = 0; p < NP; p++) begin
            nv[p] = 1; ns[p] = (p % 2 == 0); na[p] = 4; no[p] = 2'd0; nx[p] = 32'(10 * p + 3);
        end
        step("R7 sync members");
        idle(2);
        rd_chk(4, "R7 sync update");

        // R6: back-to-back groups on one word
        for (int i = 0; i < 3; i++) begin
            nv = 8'h0F; na = '{default: AW'(3)}; no = '{default: 2'd1};
            for (int p = 0; p < NP; p++) nx[p] = 32'(i * 50 + p);
            step("R6 back-to-back");
        end
        idle(2);
        rd_chk(3, "R6 chained total");

        // R8: backdoor write same cycle as a group to that word (group sees it)
        nbd_we = 1; nbd_addr = 6; nbd_wdata = 32'd1000;
        nv = 8'h03; na = '{default: AW'(6)}; nx = '{default: 32'd7};
        step("R8 write before group");
        // R8: backdoor write on the commit edge of that group (commit wins)
        nbd_we = 1; nbd_addr = 6; nbd_wdata = 32'hDEAD_BEEF;
        step("R8 collision");
        idle(2);
        rd_chk(6, "R8 commit overrides write");

        // random phase
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < NP; p++) begin
                nv[p] = ($urandom % 2) == 0;
                ns[p] = ($urandom % 4) == 0;
                na[p] = AW'($urandom % 4);
                no[p] = 2'($urandom % 4);
                nx[p] = ($urandom % 2) ? $urandom : ($urandom % 16);
            end
            if ($urandom % 8 == 0) begin
                nbd_we = 1; nbd_addr = AW'($urandom % 4); nbd_wdata = $urandom;
            end
            step("R1 R2 R5 random");
        end
        idle(3);
        for (int w = 0; w < DEPTH; w++) rd_chk(AW'(w), "R3 final words");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule